// File: doc/BRIEF.md
# Four-Channel Polyphase Channelizer

This block splits a stream of real, signed 16-bit wideband samples into four equal-width frequency channels. Samples arrive one per strobe and are dealt in turn to four FIR branches. Each branch keeps its own 20-sample history and its own slice of an 80-coefficient prototype lowpass filter. When the fourth branch of a group has produced its result, a multiplier-free 4-point FFT combines the four branch values into four complex channel values. All four channels are presented together with a single-cycle valid pulse, once for every four accepted samples.

A single multiplier is shared in time. Each accepted sample starts a 20-step multiply-accumulate pass over that branch's history, so the block suits a slow input rate on a much faster clock, for example tens of kilosamples per second on a clock of about 12 MHz. A sample that arrives while a pass is still running is dropped, and a sticky flag records the event. The coefficients are a constant table inside the block.

Top module: `chz4_top`

## Requirements
- R1: Accepted samples are dealt round-robin. Accepted sample n, counted from reset, goes to branch n mod 4 and is pushed onto the front (tap 0) of that branch's 20-entry history. Older entries move one tap back, and the oldest is discarded.
- R2: Prototype coefficient k (0..79) has the value 16*(k+1)*(80-k) - 12000. Branch b at tap t uses coefficient k = 4*t + b. The branch sum is acc_b = sum over t of coef(4t+b) * hist_b[t], held in a 38-bit signed accumulator.
- R3: Each branch result is y_b = floor((acc_b + 32768) / 65536). This is round-half-up on a right shift by 16. The result is then saturated to the signed 16-bit range [-32768, 32767].
- R4: The FFT uses the four branch values y0..y3. Define s02=y0+y2, d02=y0-y2, s13=y1+y3 and d13=y1-y3. The channels are X0=s02+s13, X1=d02-j*d13, X2=s02-s13 and X3=d02+j*d13. Each real and imaginary part v is output as floor((v+2)/4). The imaginary parts of channels 0 and 2 are therefore always 0.
- R5: Channel c is output with its real part on out_re[16c+15:16c] and its imaginary part on out_im[16c+15:16c]. All four channels are updated in the same cycle, and they hold their values until the next frame.
- R6: out_valid is high for exactly one cycle. It rises 22 clock edges after the edge that accepts every fourth sample (the one dealt to branch 3). The output buses change only at that edge.
- R7: A sample is accepted only when no pass is running. A pass occupies the 21 edges that follow the accepting edge, so the minimum accepted spacing is 22 edges.
- R8: A sample offered while a pass is running is ignored. It changes no history and does not advance the branch counter. It sets `overrun`, which stays high until reset.
- R9: While rst_n is low at a clock edge, that edge clears the histories, the branch counter, the accumulator, the branch results, out_valid, the output buses and overrun. After reset the first frame comes after four accepted samples, with all earlier history treated as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: in_sample holds a new sample |
| in_sample | input | 16 | Signed wideband input sample |
| out_valid | output | 1 | One-cycle pulse: a new four-channel frame is on the output buses |
| out_re | output | 64 | Real parts; channel c at bits [16c+15:16c] |
| out_im | output | 64 | Imaginary parts; channel c at bits [16c+15:16c] |
| overrun | output | 1 | Sticky flag: a sample arrived during a running pass |

## Verification
The hardest states to reach from the ports are saturated branch results and a dropped sample. Saturation only appears once a branch history has filled with large samples of one sign. The bench therefore drives long full-scale positive and then full-scale negative runs, which push every branch sum far past the 16-bit range. A dropped sample must also leave the round-robin order intact. To check this, the bench offers a sample five edges into a pass and then keeps comparing every later frame against a model that never saw that sample. Any slip in branch order or history shows up as wrong channel values.

// File: rtl/chz4_pkg.sv
// Package: constants and helpers shared by the four-channel channelizer.
// Assumes: the FFT is fixed at four points, so the branch count is fixed at 4.
package chz4_pkg;

    localparam int unsigned NBR = 4;      // branch count and FFT size
    localparam int unsigned BRW = 2;      // width of a branch index

    // Pass sequencer states
    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_RUN   = 2'd1,
        MS_ROUND = 2'd2
    } mac_st_t;

    // Prototype lowpass coefficient k of a filter of length len
    function automatic int proto_coef(int k, int len);
        return 16 * (k + 1) * (len - k) - 12000;
    endfunction

endpackage

// File: rtl/chz4_coef.sv
// Module: chz4_coef
// Constant coefficient store. It holds the prototype filter interleaved over
// the branches: branch br at tap tap reads coefficient tap*NBR + br.
// Assumes: NBR is a power of two, so the index is {tap, br}.
module chz4_coef
    import chz4_pkg::*;
#(
    parameter int CW   = 16,
    parameter int TAPS = 20
) (
    input  logic [BRW-1:0]              br,
    input  logic [$clog2(TAPS)-1:0]     tap,
    output logic signed [CW-1:0]        coef
);
    localparam int LEN = NBR * TAPS;
    localparam int IW  = $clog2(TAPS) + BRW;

    logic signed [CW-1:0] tbl [LEN];
    logic [IW-1:0]        idx;

    // Fill the table from the prototype formula, one entry per coefficient
    for (genvar k = 0; k < LEN; k++) begin : g_tbl
        assign tbl[k] = CW'(proto_coef(k, LEN));
    end

    // Interleaved lookup: tap selects the group, branch the member
    assign idx  = {tap, br};
    assign coef = tbl[idx];

endmodule

// File: rtl/chz4_dline.sv
// Module: chz4_dline
// Per-branch shift-register sample histories. A push shifts the sample into
// tap 0 of the selected branch. One combinational read port serves the MAC.
// Assumes: push and read never need the same branch in the same cycle
// (the sequencer reads only after the push edge).
module chz4_dline
    import chz4_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TAPS = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [BRW-1:0]              push_br,
    input  logic signed [DW-1:0]        push_dat,
    input  logic [BRW-1:0]              rd_br,
    input  logic [$clog2(TAPS)-1:0]     rd_tap,
    output logic signed [DW-1:0]        rd_dat
);
    localparam int RW = TAPS * DW;

    logic [RW-1:0] rows [NBR];

    for (genvar b = 0; b < NBR; b++) begin : g_br
        logic [RW-1:0] sr;

        // Shift history of branch b; the newest sample sits in the lowest slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr <= '0;
            end else if (push && (push_br == BRW'(b))) begin
                sr <= {sr[RW-DW-1:0], push_dat};
            end
        end

        assign rows[b] = sr;
    end

    // Read port: select branch, then tap
    assign rd_dat = rows[rd_br][rd_tap*DW +: DW];

endmodule

// File: rtl/chz4_mac.sv
// Module: chz4_mac
// Time-shared multiply-accumulate sequencer. On start it runs TAPS
// accumulate steps for one branch, then one rounding step that presents a
// saturated OW-bit result with done high.
// Assumes: start is only raised while busy is low.
module chz4_mac
    import chz4_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int AW   = 38,
    parameter int OW   = 16,
    parameter int TAPS = 20,
    parameter int RSH  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [BRW-1:0]              start_br,
    input  logic signed [DW-1:0]        samp,
    input  logic signed [CW-1:0]        coef,
    output logic [BRW-1:0]              cur_br,
    output logic [$clog2(TAPS)-1:0]     cur_tap,
    output logic                        busy,
    output logic                        done,
    output logic signed [OW-1:0]        res
);
    localparam int TW = $clog2(TAPS);
    localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (RSH - 1);
    localparam logic signed [AW:0] MAXV = (AW+1)'((2 ** (OW - 1)) - 1);
    localparam logic signed [AW:0] MINV = -MAXV - (AW+1)'(1);

    mac_st_t                  st;
    logic signed [AW-1:0]     acc;
    logic signed [DW+CW-1:0]  prod;
    logic signed [AW:0]       biased;
    logic signed [AW:0]       shifted;

    assign prod = samp * coef;

    // Sequencer: idle, TAPS accumulate steps, one rounding step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= MS_IDLE;
            acc     <= '0;
            cur_br  <= '0;
            cur_tap <= '0;
        end else begin
            case (st)
                MS_IDLE: begin
                    if (start) begin
                        st      <= MS_RUN;
                        acc     <= '0;
                        cur_br  <= start_br;
                        cur_tap <= '0;
                    end
                end
                MS_RUN: begin
                    acc <= acc + AW'(prod);
                    if (cur_tap == TW'(TAPS - 1)) begin
                        st <= MS_ROUND;
                    end else begin
                        cur_tap <= cur_tap + TW'(1);
                    end
                end
                default: begin
                    st <= MS_IDLE;
                end
            endcase
        end
    end

    // Round half up by RSH bits, then clamp to the OW-bit signed range
    always_comb begin
        biased  = {acc[AW-1], acc} + HALF;
        shifted = biased >>> RSH;
        if (shifted > MAXV) begin
            res = MAXV[OW-1:0];
        end else if (shifted < MINV) begin
            res = MINV[OW-1:0];
        end else begin
            res = shifted[OW-1:0];
        end
    end

    assign busy = (st != MS_IDLE);
    assign done = (st == MS_ROUND);

endmodule

// File: rtl/chz4_fft4.sv
// Module: chz4_fft4
// Combinational 4-point FFT of real inputs using only adds, subtracts and a
// real/imaginary swap (twiddles 1 and -j). Every output is scaled by 1/4 with
// round-half-up, so the two bits of growth never overflow OW bits.
// Assumes: inputs are real; the imaginary parts of bins 0 and 2 are zero.
module chz4_fft4
    import chz4_pkg::*;
#(
    parameter int OW = 16
) (
    input  logic signed [OW-1:0]    x [NBR],
    output logic [NBR*OW-1:0]       y_re,
    output logic [NBR*OW-1:0]       y_im
);
    localparam int GW = OW + 2;

    logic signed [GW-1:0] a [NBR];
    logic signed [GW-1:0] s02, d02, s13, d13;
    logic signed [GW-1:0] bre [NBR];
    logic signed [GW-1:0] bim [NBR];

    // Scale a grown value back to OW bits, rounding half up
    function automatic logic signed [OW-1:0] quarter(logic signed [GW-1:0] v);
        logic signed [GW-1:0] t;
        t = (v + GW'(2)) >>> 2;
        return t[OW-1:0];
    endfunction

    for (genvar i = 0; i < NBR; i++) begin : g_ext
        assign a[i] = GW'(x[i]);
    end

    // First radix-2 stage: pairs (0,2) and (1,3)
    assign s02 = a[0] + a[2];
    assign d02 = a[0] - a[2];
    assign s13 = a[1] + a[3];
    assign d13 = a[1] - a[3];

    // Second stage: twiddle -j turns d13 into an imaginary part
    assign bre[0] = s02 + s13;
    assign bim[0] = '0;
    assign bre[1] = d02;
    assign bim[1] = -d13;
    assign bre[2] = s02 - s13;
    assign bim[2] = '0;
    assign bre[3] = d02;
    assign bim[3] = d13;

    for (genvar c = 0; c < NBR; c++) begin : g_out
        assign y_re[c*OW +: OW] = quarter(bre[c]);
        assign y_im[c*OW +: OW] = quarter(bim[c]);
    end

endmodule

// File: rtl/chz4_top.sv
// Module: chz4_top
// Four-channel polyphase channelizer. Each accepted sample is dealt
// round-robin to a branch history; a shared MAC filters that branch; once
// branch NBR-1 is done, the FFT result is registered and out_valid pulses.
// Assumes: input spacing of at least 22 clocks; faster samples are dropped
// and flagged on overrun.
module chz4_top
    import chz4_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int AW   = 38,
    parameter int OW   = 16,
    parameter int TAPS = 20,
    parameter int RSH  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    in_sample,
    output logic                    out_valid,
    output logic [NBR*OW-1:0]       out_re,
    output logic [NBR*OW-1:0]       out_im,
    output logic                    overrun
);
    localparam int TW = $clog2(TAPS);

    logic                   busy;
    logic                   accept;
    logic [BRW-1:0]         rr;
    logic [BRW-1:0]         mac_br;
    logic [TW-1:0]          mac_tap;
    logic signed [DW-1:0]   hist_dat;
    logic signed [CW-1:0]   coef_dat;
    logic                   mac_done;
    logic signed [OW-1:0]   mac_res;
    logic signed [OW-1:0]   br_res [NBR];
    logic                   fft_go;
    logic [NBR*OW-1:0]      fft_re;
    logic [NBR*OW-1:0]      fft_im;

    assign accept = in_valid && !busy;

    // Round-robin branch counter, advanced only by accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr <= '0;
        end else if (accept) begin
            rr <= rr + BRW'(1);
        end
    end

    // Sticky flag for samples offered during a pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (in_valid && busy) begin
            overrun <= 1'b1;
        end
    end

    chz4_dline #(.DW(DW), .TAPS(TAPS)) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_br  (rr),
        .push_dat (in_sample),
        .rd_br    (mac_br),
        .rd_tap   (mac_tap),
        .rd_dat   (hist_dat)
    );

    chz4_coef #(.CW(CW), .TAPS(TAPS)) u_coef (
        .br   (mac_br),
        .tap  (mac_tap),
        .coef (coef_dat)
    );

    chz4_mac #(
        .DW(DW), .CW(CW), .AW(AW), .OW(OW), .TAPS(TAPS), .RSH(RSH)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_br (rr),
        .samp     (hist_dat),
        .coef     (coef_dat),
        .cur_br   (mac_br),
        .cur_tap  (mac_tap),
        .busy     (busy),
        .done     (mac_done),
        .res      (mac_res)
    );

    // Capture each branch result; launch the FFT after the last branch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBR; b++) begin
                br_res[b] <= '0;
            end
            fft_go <= 1'b0;
        end else begin
            if (mac_done) begin
                br_res[mac_br] <= mac_res;
            end
            fft_go <= mac_done && (mac_br == BRW'(NBR - 1));
        end
    end

    chz4_fft4 #(.OW(OW)) u_fft (
        .x    (br_res),
        .y_re (fft_re),
        .y_im (fft_im)
    );

    // Register the frame and raise the one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= fft_go;
            if (fft_go) begin
                out_re <= fft_re;
                out_im <= fft_im;
            end
        end
    end

endmodule

// File: rtl/chz4_chk.sv
// Module: chz4_chk
// Property checker for chz4_top, attached with bind below. It observes the
// ports and the internal pass-busy signal.
module chz4_chk #(
    parameter int RW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          busy,
    input logic          out_valid,
    input logic [RW-1:0] out_re,
    input logic [RW-1:0] out_im,
    input logic          overrun
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_re) && $stable(out_im))); // R5

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(in_valid && busy)); // R8

    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overrun && out_re == '0)); // R9
endmodule

bind chz4_top chz4_chk #(.RW(NBR*OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .overrun   (overrun)
);

// File: tb/sim_chz4_top.sv
// Bench for chz4_top: a behavioural reference model, updated on each rising
// edge and compared with the outputs on each falling edge.
module sim_chz4_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic [63:0]        out_re;
    logic [63:0]        out_im;
    logic               overrun;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit started = 0;
    bit done    = 0;
    string cur_req = "R9";

    always #5 clk = ~clk;

    chz4_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .overrun(overrun)
    );

    // ---------------- reference model ----------------
    int hist [4][20];
    int rr, bz, cnt;
    bit e_ov, e_ovr;
    int e_re [4], e_im [4], p_re [4], p_im [4];

    function automatic int coef_of(int k);
        return 16 * (k + 1) * (80 - k) - 12000;    // R2
    endfunction

    function automatic int branch_out(int b);
        longint acc = 0;
        longint v;
        for (int t = 0; t < 20; t++) acc += longint'(coef_of(4*t + b)) * hist[b][t];
        v = (acc + 32768) >>> 16;                   // R3 round half up
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    function automatic int q4(int v);
        return (v + 2) >>> 2;                       // R4 scale by 1/4
    endfunction

    task automatic make_frame();
        int y [4];
        for (int b = 0; b < 4; b++) y[b] = branch_out(b);
        p_re[0] = q4(y[0] + y[2] + y[1] + y[3]);  p_im[0] = 0;
        p_re[1] = q4(y[0] - y[2]);                 p_im[1] = q4(y[3] - y[1]);
        p_re[2] = q4(y[0] + y[2] - y[1] - y[3]);  p_im[2] = 0;
        p_re[3] = q4(y[0] - y[2]);                 p_im[3] = q4(y[1] - y[3]);
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                for (int t = 0; t < 20; t++) hist[b][t] = 0;
                e_re[b] = 0; e_im[b] = 0;
            end
            rr = 0; bz = 0; cnt = 0; e_ov = 0; e_ovr = 0;
        end else begin
            bit acc_now;
            e_ov = (cnt == 1);
            if (cnt == 1) begin e_re = p_re; e_im = p_im; end
            if (cnt > 0) cnt--;
            acc_now = 0;
            if (in_valid) begin
                if (bz > 0) e_ovr = 1; else acc_now = 1;
            end
            if (bz > 0) bz--;
            if (acc_now) begin
                for (int t = 19; t > 0; t--) hist[rr][t] = hist[rr][t-1];
                hist[rr][0] = int'(in_sample);
                if (rr == 3) begin make_frame(); cnt = 22; end
                rr = (rr + 1) % 4;
                bz = 21;
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check(out_valid === e_ov, "R6", "out_valid", out_valid, e_ov);
            check(overrun === e_ovr, "R8", "overrun", overrun, e_ovr);
            for (int c = 0; c < 4; c++) begin
                int ar, ai;
                ar = int'($signed(out_re[c*16 +: 16]));
                ai = int'($signed(out_im[c*16 +: 16]));
                // R5 channel placement, values per the current stimulus requirement
                check(ar == e_re[c], cur_req, $sformatf("re ch%0d", c), ar, e_re[c]);
                check(ai == e_im[c], cur_req, $sformatf("im ch%0d", c), ai, e_im[c]);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(int v, int gap);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(v);
        @(negedge clk);
        in_valid  = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    initial begin
        int seed = 7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                           // R9 reset state checked above
        repeat (2) @(negedge clk);

        cur_req = "R2";                         // impulse exposes each coefficient
        send(30000, 24);
        for (int i = 0; i < 27; i++) send(0, 24);
        send(0, 24); send(-25000, 24);
        for (int i = 0; i < 26; i++) send(0, 24);

        cur_req = "R1";                         // ramp: branch order matters
        for (int i = 0; i < 40; i++) send(i * 300 - 6000, 24);

        cur_req = "R4";                         // small random values
        for (int i = 0; i < 60; i++) send(($urandom(seed + i) % 4001) - 2000, 23);

        cur_req = "R3";                         // saturation both ways
        for (int i = 0; i < 84; i++) send(32767, 22);
        for (int i = 0; i < 84; i++) send(-32768, 22);

        cur_req = "R7";                         // minimum spacing, then a dropped sample
        for (int i = 0; i < 8; i++) send(1000 * i, 22);
        send(12000, 5);                         // R8: next one lands mid-pass
        send(-9000, 24);
        for (int i = 0; i < 16; i++) send(500 - 70 * i, 24);

        cur_req = "R9";                         // reset mid-stream
        send(7000, 8);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) send(4000 - 900 * i, 24);
        repeat (30) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule